// File: doc/BRIEF.md
# Data Memory Space Access Router

This block sits between an 8051-style CPU core and the internal data stores. Each cycle it takes one access (address, addressing-mode tag, read and write strobes, write data). It raises exactly one target select: lower RAM, upper RAM, the special function register bus, on-chip expanded RAM (ERAM), or a request to the external bus. The addresses 80H–FFH are shared by the register bus and upper RAM. The addressing mode alone decides which of the two is meant. A MOVX access goes to ERAM or to the external bus, depending on a mapping bit.

The router owns a small control register at direct address 8EH. Bit 1 sends MOVX traffic to the external bus. Bit 0 limits the address latch strobe to off-chip accesses. Selects and address outputs follow the request in the same cycle. Read data comes back one cycle after the read, taken from whichever target was selected. The ERAM size is a build parameter of at least 256 bytes (256 or 768 are the intended values).

Top module: `dmem_router`

## Requirements
- R1: A request with mode direct (00) or indirect (01) and address byte 00H–7FH raises lo_sel only.
- R2: For address bytes 80H–FFH, mode direct raises sfr_sel, except at 8EH. Mode indirect raises up_sel.
- R3: With the mapping bit (control bit 1) clear, a MOVX @DPTR request (mode 11) below ERAM_BYTES raises eram_sel with eram_addr equal to the address. ext_rd and ext_wr stay low.
- R4: With the mapping bit clear, MOVX @DPTR at or above ERAM_BYTES raises ext_req with ext_wide=1 and the full 16-bit ext_addr. ext_rd or ext_wr follows the strobe.
- R5: With the mapping bit set, every MOVX request raises ext_req. Mode 10 (@Ri) gives ext_wide=0 and ext_addr={00H, address[7:0]}. Mode 11 gives ext_wide=1 and the full address.
- R6: With the mapping bit clear, MOVX @Ri (mode 10) raises eram_sel with eram_addr = address[7:0].
- R7: The control register is reached by mode direct at 8EH. A write stores wdata[1:0] as {map bit, ALE bit}, which takes effect from the next cycle. Both bits clear on reset. A read returns {000000b, map, ALE}. No target select is raised for it.
- R8: ale_free is high while the ALE bit (control bit 0) is clear and low while it is set.
- R9: A request with stack_acc high raises lo_sel (address byte below 80H) or up_sel (byte 80H and above), whatever the mode.
- R10: rdata, one cycle after a read, carries the selected target's read-data input. After a cycle without a read it is 00H.
- R11: Without rd_en or wr_en, no select, ext_rd or ext_wr is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| acc_mode | input | 2 | 00 direct, 01 indirect, 10 MOVX @Ri, 11 MOVX @DPTR |
| stack_acc | input | 1 | Access is a stack push or pop |
| addr | input | 16 | Request address (low byte only for non-DPTR modes) |
| wdata | input | 8 | Write data |
| lo_rdata | input | 8 | Lower RAM read data |
| up_rdata | input | 8 | Upper RAM read data |
| sfr_rdata | input | 8 | Register bus read data |
| eram_rdata | input | 8 | ERAM read data |
| ext_rdata | input | 8 | External bus read data |
| lo_sel | output | 1 | Lower RAM select |
| up_sel | output | 1 | Upper RAM select |
| sfr_sel | output | 1 | Register bus select |
| eram_sel | output | 1 | ERAM select |
| ext_req | output | 1 | External access request |
| loc_addr | output | 8 | Address byte for lower/upper RAM and register bus |
| eram_addr | output | ERAM_AW | ERAM address |
| ext_addr | output | 16 | External address |
| ext_wide | output | 1 | External address is 16-bit |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ale_free | output | 1 | Address latch strobe free-running |
| rdata | output | 8 | Read data, one cycle after the read |

## Verification
The mapping bit held in the control register is the only state that changes routing. If it is wrong, the next MOVX shows it at once: eram_sel and ext_req swap, and ext_rd or ext_wr appears or vanishes. A wrong ALE bit shows on ale_free in the same cycle. A stale registered read target shows up in rdata on the cycle after the read, as another target's data or as a non-zero value after an idle cycle. For this reason the bench reads each routed target back and reads the control register after every reset and every write to it.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT    = 2'b00,
        AM_INDIRECT  = 2'b01,
        AM_MOVX_RI   = 2'b10,
        AM_MOVX_DPTR = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        TG_NONE = 3'd0,
        TG_LO   = 3'd1,
        TG_UP   = 3'd2,
        TG_SFR  = 3'd3,
        TG_ERAM = 3'd4,
        TG_EXT  = 3'd5,
        TG_CTRL = 3'd6
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic wide;
    } route_t;

    typedef struct packed {
        logic map_ext;
        logic ale_gate;
    } ctrl_t;

    localparam logic [7:0] CTRL_ADDR = 8'h8E;

    function automatic tgt_e ram_half(input logic [7:0] a);
        return a[7] ? TG_UP : TG_LO;
    endfunction

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int ERAM_BYTES = 256
) (
    input  logic        access,
    input  logic [1:0]  acc_mode,
    input  logic        stack_acc,
    input  logic [15:0] addr,
    input  logic        map_ext,
    output route_t      route
);
    localparam logic [16:0] ERAM_TOP = 17'(ERAM_BYTES);

    amode_e mode;
    logic   in_eram;

    assign mode    = amode_e'(acc_mode);
    assign in_eram = ({1'b0, addr} < ERAM_TOP);

    always_comb begin
        route = '{tgt: TG_NONE, wide: 1'b0};
        if (access) begin
            if (stack_acc) begin
                route.tgt = ram_half(addr[7:0]);
            end else begin
                unique case (mode)
                    AM_DIRECT: begin
                        if (!addr[7])                  route.tgt = TG_LO;
                        else if (addr[7:0] == CTRL_ADDR) route.tgt = TG_CTRL;
                        else                           route.tgt = TG_SFR;
                    end
                    AM_INDIRECT: route.tgt = ram_half(addr[7:0]);
                    AM_MOVX_RI: begin
                        route.tgt  = map_ext ? TG_EXT : TG_ERAM;
                        route.wide = 1'b0;
                    end
                    AM_MOVX_DPTR: begin
                        route.tgt  = (!map_ext && in_eram) ? TG_ERAM : TG_EXT;
                        route.wide = 1'b1;
                    end
                    default: route.tgt = TG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmem_ctrl_reg.sv
module dmem_ctrl_reg
    import dmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  logic [1:0] wbits,
    output ctrl_t      ctrl
);
    always_ff @(posedge clk) begin
        if (rst)         ctrl <= '0;
        else if (wr_hit) ctrl <= ctrl_t'(wbits);
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctrl)); // R7
endmodule

// File: rtl/dmem_rdmux.sv
module dmem_rdmux
    import dmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  tgt_e       tgt,
    input  ctrl_t      ctrl,
    input  logic [7:0] lo_rdata,
    input  logic [7:0] up_rdata,
    input  logic [7:0] sfr_rdata,
    input  logic [7:0] eram_rdata,
    input  logic [7:0] ext_rdata,
    output logic [7:0] rdata
);
    tgt_e  tgt_q;
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= TG_NONE;
            ctrl_q <= '0;
        end else begin
            tgt_q  <= rd_en ? tgt : TG_NONE;
            ctrl_q <= ctrl;
        end
    end

    always_comb begin
        unique case (tgt_q)
            TG_LO:   rdata = lo_rdata;
            TG_UP:   rdata = up_rdata;
            TG_SFR:  rdata = sfr_rdata;
            TG_ERAM: rdata = eram_rdata;
            TG_EXT:  rdata = ext_rdata;
            TG_CTRL: rdata = {6'b0, ctrl_q.map_ext, ctrl_q.ale_gate};
            default: rdata = 8'h00;
        endcase
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == 8'h00)); // R10
endmodule

// File: rtl/dmem_router.sv
module dmem_router
    import dmem_pkg::*;
#(
    parameter int   ERAM_BYTES = 256,
    localparam int  ERAM_AW    = $clog2(ERAM_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [1:0]         acc_mode,
    input  logic               stack_acc,
    input  logic [15:0]        addr,
    input  logic [7:0]         wdata,
    input  logic [7:0]         lo_rdata,
    input  logic [7:0]         up_rdata,
    input  logic [7:0]         sfr_rdata,
    input  logic [7:0]         eram_rdata,
    input  logic [7:0]         ext_rdata,
    output logic               lo_sel,
    output logic               up_sel,
    output logic               sfr_sel,
    output logic               eram_sel,
    output logic               ext_req,
    output logic [7:0]         loc_addr,
    output logic [ERAM_AW-1:0] eram_addr,
    output logic [15:0]        ext_addr,
    output logic               ext_wide,
    output logic               ext_rd,
    output logic               ext_wr,
    output logic               ale_free,
    output logic [7:0]         rdata
);
    logic   access;
    route_t route;
    ctrl_t  ctrl;

    assign access = rd_en | wr_en;

    dmem_decode #(.ERAM_BYTES(ERAM_BYTES)) u_dec (
        .access   (access),
        .acc_mode (acc_mode),
        .stack_acc(stack_acc),
        .addr     (addr),
        .map_ext  (ctrl.map_ext),
        .route    (route)
    );

    dmem_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_hit(wr_en && (route.tgt == TG_CTRL)),
        .wbits (wdata[1:0]),
        .ctrl  (ctrl)
    );

    dmem_rdmux u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .tgt       (route.tgt),
        .ctrl      (ctrl),
        .lo_rdata  (lo_rdata),
        .up_rdata  (up_rdata),
        .sfr_rdata (sfr_rdata),
        .eram_rdata(eram_rdata),
        .ext_rdata (ext_rdata),
        .rdata     (rdata)
    );

    assign lo_sel   = (route.tgt == TG_LO);
    assign up_sel   = (route.tgt == TG_UP);
    assign sfr_sel  = (route.tgt == TG_SFR);
    assign eram_sel = (route.tgt == TG_ERAM);
    assign ext_req  = (route.tgt == TG_EXT);
    assign ext_wide = ext_req & route.wide;
    assign ext_rd   = ext_req & rd_en;
    assign ext_wr   = ext_req & wr_en;
    assign ale_free = ~ctrl.ale_gate;
    assign loc_addr = addr[7:0];
    assign ext_addr = route.wide ? addr : {8'h00, addr[7:0]};

    generate
        if (ERAM_AW > 8) begin : g_wide_eram
            assign eram_addr = (acc_mode == AM_MOVX_RI) ?
                               {{(ERAM_AW-8){1'b0}}, addr[7:0]} : addr[ERAM_AW-1:0];
        end else begin : g_byte_eram
            assign eram_addr = addr[ERAM_AW-1:0];
        end
    endgenerate

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lo_sel, up_sel, sfr_sel, eram_sel, ext_req})); // R1
    AST_ERAM_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        eram_sel |-> (!ext_rd && !ext_wr)); // R3
    AST_RI_NARROW: assert property (@(posedge clk) disable iff (rst)
        (ext_req && acc_mode == AM_MOVX_RI) |-> (!ext_wide && ext_addr[15:8] == 8'h00)); // R5
    AST_STACK_INTERNAL: assert property (@(posedge clk) disable iff (rst)
        (stack_acc && access) |-> (lo_sel || up_sel)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !access |-> !(lo_sel || up_sel || sfr_sel || eram_sel || ext_req || ext_rd || ext_wr)); // R11
endmodule

// File: tb/sim_dmem_router.sv
module sim_dmem_router;
    localparam int ERAM_BYTES = 256;
    localparam int AW = $clog2(ERAM_BYTES);
    localparam int NV = 15;
    // {ctrl[1:0], stack, mode[1:0], addr[15:0], expected {lo,up,sfr,eram,ext}}
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 1'b0, 2'd0, 16'h0005, 5'b10000},
        {2'd0, 1'b0, 2'd1, 16'h007F, 5'b10000},
        {2'd0, 1'b0, 2'd0, 16'h00A0, 5'b00100},
        {2'd0, 1'b0, 2'd1, 16'h00A0, 5'b01000},
        {2'd0, 1'b0, 2'd2, 16'h00A0, 5'b00010},
        {2'd0, 1'b0, 2'd3, 16'h00FF, 5'b00010},
        {2'd0, 1'b0, 2'd3, 16'h0100, 5'b00001},
        {2'd0, 1'b0, 2'd3, 16'hFFFF, 5'b00001},
        {2'd0, 1'b1, 2'd2, 16'h0090, 5'b01000},
        {2'd0, 1'b1, 2'd3, 16'h0234, 5'b10000},
        {2'd2, 1'b0, 2'd2, 16'h0033, 5'b00001},
        {2'd2, 1'b0, 2'd3, 16'h0010, 5'b00001},
        {2'd2, 1'b0, 2'd0, 16'h0080, 5'b00100},
        {2'd2, 1'b0, 2'd1, 16'h0010, 5'b10000},
        {2'd2, 1'b1, 2'd0, 16'h00C0, 5'b01000}
    };

    logic clk = 0, rst = 1, rd_en = 0, wr_en = 0, stack_acc = 0;
    logic [1:0] acc_mode = 0;
    logic [15:0] addr = 0;
    logic [7:0] wdata = 0;
    logic lo_sel, up_sel, sfr_sel, eram_sel, ext_req, ext_wide, ext_rd, ext_wr, ale_free;
    logic [7:0] loc_addr, rdata;
    logic [AW-1:0] eram_addr;
    logic [15:0] ext_addr;
    int n_run = 0, n_fail = 0;
    logic [1:0] cur_ctrl = 0;

    always #5 clk = ~clk;

    dmem_router #(.ERAM_BYTES(ERAM_BYTES)) u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .acc_mode(acc_mode),
        .stack_acc(stack_acc), .addr(addr), .wdata(wdata),
        .lo_rdata(8'h11), .up_rdata(8'h22), .sfr_rdata(8'h33),
        .eram_rdata(8'h44), .ext_rdata(8'h55),
        .lo_sel(lo_sel), .up_sel(up_sel), .sfr_sel(sfr_sel), .eram_sel(eram_sel),
        .ext_req(ext_req), .loc_addr(loc_addr), .eram_addr(eram_addr),
        .ext_addr(ext_addr), .ext_wide(ext_wide), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ale_free(ale_free), .rdata(rdata)
    );

    function automatic logic [4:0] sels();
        return {lo_sel, up_sel, sfr_sel, eram_sel, ext_req};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic go_idle();
        rd_en = 0; wr_en = 0; stack_acc = 0; acc_mode = 0; addr = 0; wdata = 0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1; acc_mode = 2'd0; addr = 16'h008E; wdata = v;
        #2 chk("R7", "ctrl write selects", {27'd0, sels()}, 32'd0);
        @(negedge clk);
        go_idle();
        cur_ctrl = v[1:0];
    endtask

    task automatic rd_ctrl(input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1; acc_mode = 2'd0; addr = 16'h008E;
        #2 chk(tag, "ctrl read selects", {27'd0, sels()}, 32'd0);
        @(negedge clk);
        chk(tag, "ctrl readback", {24'd0, rdata}, {24'd0, exp});
        go_idle();
    endtask

    task automatic run_vec(input logic [25:0] v);
        logic [4:0] ex;
        logic [7:0] exd;
        string tag;
        ex = v[4:0];
        if (v[25:24] != cur_ctrl) wr_ctrl({6'd0, v[25:24]});
        if (v[23]) tag = "R9";
        else if (ex[1] && v[22:21] == 2'd2) tag = "R6";
        else if (ex[1]) tag = "R3";
        else if (ex[0] && v[25]) tag = "R5";
        else if (ex[0]) tag = "R4";
        else if (v[12]) tag = "R2";
        else tag = "R1";
        exd = ex[4] ? 8'h11 : ex[3] ? 8'h22 : ex[2] ? 8'h33 : ex[1] ? 8'h44 : 8'h55;
        @(negedge clk);
        rd_en = 1; stack_acc = v[23]; acc_mode = v[22:21]; addr = v[20:5];
        #2;
        chk(tag, "selects", {27'd0, sels()}, {27'd0, ex});
        chk(tag, "ext_rd", {31'd0, ext_rd}, {31'd0, ex[0]});
        if (ex[1]) chk(tag, "eram_addr", {24'd0, eram_addr}, {24'd0, addr[7:0]});
        if (ex[0]) begin
            chk(tag, "ext_wide", {31'd0, ext_wide}, {31'd0, acc_mode == 2'd3});
            chk(tag, "ext_addr", {16'd0, ext_addr},
                {16'd0, (acc_mode == 2'd3) ? addr : {8'h00, addr[7:0]}});
        end
        @(negedge clk);
        chk("R10", "rdata", {24'd0, rdata}, {24'd0, exd});
        go_idle();
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        chk("R11", "idle selects after reset", {27'd0, sels()}, 32'd0);
        chk("R11", "idle strobes", {30'd0, ext_rd, ext_wr}, 32'd0);
        chk("R8", "ale_free after reset", {31'd0, ale_free}, 32'd1);
        chk("R10", "rdata after reset", {24'd0, rdata}, 32'd0);
        rd_ctrl(8'h00, "R7");

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        wr_ctrl(8'hFF);
        chk("R8", "ale_free with ALE bit", {31'd0, ale_free}, 32'd0);
        rd_ctrl(8'h03, "R7");
        wr_ctrl(8'h01);
        rd_ctrl(8'h01, "R7");
        // ALE bit alone leaves MOVX on ERAM
        run_vec({2'd1, 1'b0, 2'd3, 16'h0010, 5'b00010});
        wr_ctrl(8'h00);
        chk("R8", "ale_free cleared", {31'd0, ale_free}, 32'd1);

        // read then idle: rdata returns to zero (R10)
        run_vec({2'd0, 1'b0, 2'd1, 16'h0001, 5'b10000});
        @(negedge clk);
        chk("R10", "rdata after idle", {24'd0, rdata}, 32'd0);

        // ERAM write keeps external strobes low (R3)
        @(negedge clk);
        wr_en = 1; acc_mode = 2'd3; addr = 16'h0040;
        #2 chk("R3", "eram write select", {27'd0, sels()}, 32'b00010);
        chk("R3", "eram write strobes", {30'd0, ext_rd, ext_wr}, 32'd0);
        @(negedge clk);
        chk("R10", "rdata after write", {24'd0, rdata}, 32'd0);
        // external write (R4)
        addr = 16'h1234;
        #2 chk("R4", "ext write strobes", {30'd0, ext_rd, ext_wr}, 32'b01);
        chk("R4", "ext write addr", {16'd0, ext_addr}, 32'h1234);
        @(negedge clk);
        go_idle();

        // no strobe: nothing selected (R11)
        acc_mode = 2'd3; addr = 16'h0300; stack_acc = 1;
        #2 chk("R11", "no-strobe selects", {29'd0, sels()[2:0], ext_wr}, 32'd0);
        go_idle();

        // reset clears control register (R7)
        wr_ctrl(8'h02);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        cur_ctrl = 0;
        rd_ctrl(8'h00, "R7");
        run_vec({2'd0, 1'b0, 2'd2, 16'h0077, 5'b00010});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule